// File: doc/BRIEF.md
# In-Order Reorder Buffer with Precise Flush

This block keeps the program order of instructions that run out of order. It is a ring of `DEPTH` slots with a head index and a tail index, and both indices wrap modulo `DEPTH`. An issue stage places one instruction per cycle at the tail, with its destination register index. The slot number it receives is the tag for that instruction. Execution units report back by tag. A report marks the slot as completed with a result value, or as faulted.

The oldest slot is at the head. It commits only after it has completed, and the slot and its result appear on the retire outputs in that cycle. A faulted head is never committed. The block raises an exception strobe instead and drops that slot and everything younger. A branch-mispredict request names a live slot. The block keeps that slot, discards every younger one, and reports in the same cycle how many it discarded. Full and empty are told apart by pointers alone, so one slot always stays unused.

Top module: `rob_core`

## Requirements
- R1: When head equals tail the buffer is empty: `occupancy` is 0 and both `ret_valid` and `exc_valid` are low. Reset leaves the buffer empty with `iss_slot` at 0.
- R2: The buffer is full when (tail + 1) mod DEPTH equals head, so it holds at most DEPTH-1 entries. While full, `iss_ready` is low and an issue request changes nothing.
- R3: An accepted issue (`iss_valid` and `iss_ready` high) writes the slot shown on `iss_slot`, which is the tail. That slot becomes pending, and `iss_slot` advances by one modulo DEPTH at the clock edge.
- R4: Only the head may retire. `ret_valid` is high, with `ret_dest` and `ret_value` taken from the head, in exactly those cycles when the head has completed. The head advances at that edge. A pending head holds retirement even when younger slots have completed.
- R5: A faulted head raises `exc_valid` and never raises `ret_valid`. At the next edge the buffer is empty (tail and head both land just past the faulting slot), and completed younger entries are discarded. `iss_ready` is low in that cycle.
- R6: A mispredict on live slot b reports (tail - b - 1) mod DEPTH on `br_drop_cnt` in the same cycle. At the next edge the tail becomes (b + 1) mod DEPTH and slot b stays live, whether or not the discarded range wraps.
- R7: `occupancy` equals (tail - head) mod DEPTH. It always matches accepted issues minus retirements, minus discarded entries.
- R8: A completion whose slot is not live, including any slot number of DEPTH or more, changes no entry.
- R9: While `br_valid` is high, `iss_ready` is low. The flush takes priority and the issue is refused.
- R10: A completion on a live slot takes effect at the next edge. A low `cmp_fault` marks the slot completed with `cmp_value`, and a high `cmp_fault` marks it faulted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_dest | input | REG_W | Destination register index of the issued instruction |
| iss_ready | output | 1 | Issue accepted this cycle if requested |
| iss_slot | output | IDX_W | Slot (tag) an issue in this cycle receives; equals the tail |
| cmp_valid | input | 1 | Completion report |
| cmp_slot | input | IDX_W | Slot being completed |
| cmp_fault | input | 1 | 1: the instruction faulted, 0: it completed normally |
| cmp_value | input | DATA_W | Result value |
| br_valid | input | 1 | Mispredict flush request |
| br_slot | input | IDX_W | Slot of the mispredicted branch (kept) |
| br_drop_cnt | output | IDX_W | Number of entries the flush discards |
| ret_valid | output | 1 | Head commits this cycle |
| ret_dest | output | REG_W | Destination index of the head |
| ret_value | output | DATA_W | Result value of the head |
| exc_valid | output | 1 | Head faulted; buffer is flushed at this edge |
| occupancy | output | IDX_W | Live entry count |

## Verification
The retire, exception, ready, drop-count and occupancy outputs are all combinational in the current state and inputs. So the bench drives each vector just after a falling edge and compares those outputs 1 ns later, before the rising edge that acts on them. A completion or issue first shows on the outputs in the next vector, one edge later. The expected table is laid out on that rule: a completion written in vector k shows `ret_valid` in vector k+1. A flush moves `iss_slot` and `occupancy` in the vector after the request, and `br_drop_cnt` is checked in the request's own vector.

// File: rtl/rob_pkg.sv
package rob_pkg;

   // life cycle of one ring slot
   typedef enum logic [1:0] {
      SLOT_FREE  = 2'd0,
      SLOT_WAIT  = 2'd1,
      SLOT_DONE  = 2'd2,
      SLOT_FAULT = 2'd3
   } slot_state_e;

endpackage

// File: rtl/rob_ring_ptrs.sv
module rob_ring_ptrs #(
   parameter int unsigned DEPTH = 6,
   parameter int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_head,
   input  logic             adv_tail,
   input  logic             exc_flush,
   input  logic             br_flush,
   input  logic [IDX_W-1:0] br_slot,
   input  logic [IDX_W-1:0] cmp_slot,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic [IDX_W-1:0] occ,
   output logic [IDX_W-1:0] br_drop,
   output logic             full,
   output logic             empty,
   output logic             cmp_live,
   output logic             br_live
);

   localparam logic [IDX_W:0]   DEPTH_W = (IDX_W+1)'(DEPTH);
   localparam logic [IDX_W-1:0] LAST    = IDX_W'(DEPTH - 1);
   localparam bit               POW2    = (DEPTH == (1 << IDX_W));

   if (DEPTH < 2) begin : g_depth_bad
      $error("rob_ring_ptrs: DEPTH must be at least 2");
   end

   logic [IDX_W-1:0] head_q, tail_q;
   logic [IDX_W-1:0] head_inc, tail_inc, br_inc;

   // modular difference a - b over the ring
   function automatic logic [IDX_W-1:0] ring_sub(input logic [IDX_W-1:0] a,
                                                 input logic [IDX_W-1:0] b);
      logic [IDX_W:0] wide;
      if (a >= b) wide = {1'b0, a} - {1'b0, b};
      else        wide = {1'b0, a} + DEPTH_W - {1'b0, b};
      return wide[IDX_W-1:0];
   endfunction

   // wrap-around increment: free for power-of-two depths, compare otherwise
   if (POW2) begin : g_wrap_free
      assign head_inc = head_q + 1'b1;
      assign tail_inc = tail_q + 1'b1;
      assign br_inc   = br_slot + 1'b1;
   end else begin : g_wrap_cmp
      assign head_inc = (head_q == LAST)  ? '0 : head_q + 1'b1;
      assign tail_inc = (tail_q == LAST)  ? '0 : tail_q + 1'b1;
      assign br_inc   = (br_slot == LAST) ? '0 : br_slot + 1'b1;
   end

   assign head     = head_q;
   assign tail     = tail_q;
   assign occ      = ring_sub(tail_q, head_q);
   assign empty    = (head_q == tail_q);
   assign full     = (tail_inc == head_q);
   assign cmp_live = ({1'b0, cmp_slot} < DEPTH_W) && (ring_sub(cmp_slot, head_q) < occ);
   assign br_live  = ({1'b0, br_slot} < DEPTH_W) && (ring_sub(br_slot, head_q) < occ);
   assign br_drop  = ring_sub(tail_q, br_inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else if (exc_flush) begin
         head_q <= head_inc;
         tail_q <= head_inc;
      end else begin
         if (adv_head) head_q <= head_inc;
         if (br_flush)      tail_q <= br_inc;
         else if (adv_tail) tail_q <= tail_inc;
      end
   end

   // R2
   occ_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= LAST);

   // R2
   no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !adv_tail);

   // R6
   br_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      br_flush && !exc_flush |=> ring_sub(tail_q, $past(br_slot)) == IDX_W'(1));

   // R5
   exc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_flush |=> empty);

endmodule

// File: rtl/rob_slot_store.sv
module rob_slot_store
   import rob_pkg::*;
#(
   parameter int unsigned DEPTH  = 6,
   parameter int unsigned IDX_W  = $clog2(DEPTH),
   parameter int unsigned REG_W  = 5,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_slot,
   input  logic [REG_W-1:0]  wr_dest,
   input  logic              cm_en,
   input  logic [IDX_W-1:0]  cm_slot,
   input  logic              cm_fault,
   input  logic [DATA_W-1:0] cm_value,
   input  logic [IDX_W-1:0]  rd_slot,
   output slot_state_e       rd_state,
   output logic [REG_W-1:0]  rd_dest,
   output logic [DATA_W-1:0] rd_value
);

   slot_state_e       st_q   [DEPTH];
   logic [REG_W-1:0]  dest_q [DEPTH];
   logic [DATA_W-1:0] val_q  [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            st_q[i]   <= SLOT_FREE;
            dest_q[i] <= '0;
            val_q[i]  <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && wr_slot == IDX_W'(i)) begin
               st_q[i]   <= SLOT_WAIT;
               dest_q[i] <= wr_dest;
            end
            // completion is gated to live slots upstream, so it never meets the tail
            if (cm_en && cm_slot == IDX_W'(i)) begin
               st_q[i]  <= cm_fault ? SLOT_FAULT : SLOT_DONE;
               val_q[i] <= cm_value;
            end
         end
      end
   end

   assign rd_state = st_q[rd_slot];
   assign rd_dest  = dest_q[rd_slot];
   assign rd_value = val_q[rd_slot];

   // R3
   issue_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> st_q[$past(wr_slot)] == SLOT_WAIT);

   // R10
   complete_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cm_en && !cm_fault |=> st_q[$past(cm_slot)] == SLOT_DONE
                             && val_q[$past(cm_slot)] == $past(cm_value));

   // R10
   fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cm_en && cm_fault |=> st_q[$past(cm_slot)] == SLOT_FAULT);

endmodule

// File: rtl/rob_core.sv
module rob_core
   import rob_pkg::*;
#(
   parameter int unsigned DEPTH  = 6,
   parameter int unsigned REG_W  = 5,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [REG_W-1:0]  iss_dest,
   output logic              iss_ready,
   output logic [IDX_W-1:0]  iss_slot,
   input  logic              cmp_valid,
   input  logic [IDX_W-1:0]  cmp_slot,
   input  logic              cmp_fault,
   input  logic [DATA_W-1:0] cmp_value,
   input  logic              br_valid,
   input  logic [IDX_W-1:0]  br_slot,
   output logic [IDX_W-1:0]  br_drop_cnt,
   output logic              ret_valid,
   output logic [REG_W-1:0]  ret_dest,
   output logic [DATA_W-1:0] ret_value,
   output logic              exc_valid,
   output logic [IDX_W-1:0]  occupancy
);

   if (REG_W < 1 || DATA_W < 1) begin : g_width_bad
      $error("rob_core: REG_W and DATA_W must be at least 1");
   end

   logic [IDX_W-1:0] head, tail, occ, br_drop;
   logic             full, empty, cmp_live, br_live;
   logic             iss_fire, cmp_en, br_fire;
   slot_state_e      head_state;

   assign ret_valid   = !empty && (head_state == SLOT_DONE);
   assign exc_valid   = !empty && (head_state == SLOT_FAULT);
   assign iss_ready   = !full && !br_valid && !exc_valid;
   assign iss_fire    = iss_valid && iss_ready;
   assign cmp_en      = cmp_valid && cmp_live;
   assign br_fire     = br_valid && br_live && !exc_valid;
   assign br_drop_cnt = br_fire ? br_drop : '0;
   assign iss_slot    = tail;
   assign occupancy   = occ;

   rob_ring_ptrs #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W)
   ) u_ptrs (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_head  (ret_valid),
      .adv_tail  (iss_fire),
      .exc_flush (exc_valid),
      .br_flush  (br_fire),
      .br_slot   (br_slot),
      .cmp_slot  (cmp_slot),
      .head      (head),
      .tail      (tail),
      .occ       (occ),
      .br_drop   (br_drop),
      .full      (full),
      .empty     (empty),
      .cmp_live  (cmp_live),
      .br_live   (br_live)
   );

   rob_slot_store #(
      .DEPTH  (DEPTH),
      .IDX_W  (IDX_W),
      .REG_W  (REG_W),
      .DATA_W (DATA_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (iss_fire),
      .wr_slot  (tail),
      .wr_dest  (iss_dest),
      .cm_en    (cmp_en),
      .cm_slot  (cmp_slot),
      .cm_fault (cmp_fault),
      .cm_value (cmp_value),
      .rd_slot  (head),
      .rd_state (head_state),
      .rd_dest  (ret_dest),
      .rd_value (ret_value)
   );

   // independent tally of live entries: issued minus retired minus discarded
   int live_tally;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         live_tally <= 0;
      else if (exc_valid) live_tally <= 0;
      else                live_tally <= live_tally + int'(iss_fire) - int'(ret_valid)
                                        - int'(br_drop_cnt);
   end

   // R7
   occ_tally_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occupancy) == live_tally);

   // R1
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy == '0 |-> !ret_valid && !exc_valid);

   // R4
   head_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ret_valid && !exc_valid |=> $stable(head));

   // R9
   br_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid |-> !iss_ready);

   // R5
   exc_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> !ret_valid && !iss_ready);

endmodule

// File: tb/tb_rob_core.sv
module tb_rob_core;

   localparam int DEPTH = 6;
   localparam int REG_W = 3;
   localparam int DATA_W = 8;
   localparam int IDX_W = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              iss_valid = 1'b0;
   logic [REG_W-1:0]  iss_dest = '0;
   logic              iss_ready;
   logic [IDX_W-1:0]  iss_slot;
   logic              cmp_valid = 1'b0;
   logic [IDX_W-1:0]  cmp_slot = '0;
   logic              cmp_fault = 1'b0;
   logic [DATA_W-1:0] cmp_value = '0;
   logic              br_valid = 1'b0;
   logic [IDX_W-1:0]  br_slot = '0;
   logic [IDX_W-1:0]  br_drop_cnt;
   logic              ret_valid;
   logic [REG_W-1:0]  ret_dest;
   logic [DATA_W-1:0] ret_value;
   logic              exc_valid;
   logic [IDX_W-1:0]  occupancy;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   rob_core #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_dest(iss_dest), .iss_ready(iss_ready), .iss_slot(iss_slot),
      .cmp_valid(cmp_valid), .cmp_slot(cmp_slot), .cmp_fault(cmp_fault), .cmp_value(cmp_value),
      .br_valid(br_valid), .br_slot(br_slot), .br_drop_cnt(br_drop_cnt),
      .ret_valid(ret_valid), .ret_dest(ret_dest), .ret_value(ret_value),
      .exc_valid(exc_valid), .occupancy(occupancy)
   );

   typedef struct packed {
      logic       iv;  logic [2:0] id;
      logic       cv;  logic [2:0] cs;  logic cf;  logic [7:0] cval;
      logic       bv;  logic [2:0] bs;
      logic       erdy; logic erv; logic [7:0] eval; logic eexc;
      logic [2:0] eocc; logic [2:0] eslot; logic [2:0] efc;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 35;
   // iv id cv cs cf cval bv bs | rdy rv val exc occ slot drop | req
   localparam vec_t VEC [NV] = '{
      '{1,1, 0,0,0, 0, 0,0, 1,0, 0,0, 0,0,0, 3},  // R3 first issue at slot 0
      '{1,2, 1,0,0,25, 0,0, 1,0, 0,0, 1,1,0, 10}, // R10 complete slot 0
      '{1,3, 0,0,0, 0, 0,0, 1,1,25,0, 2,2,0, 4},  // R4 head commits
      '{0,0, 1,2,0,40, 0,0, 1,0, 0,0, 2,3,0, 4},  // R4 younger done, head pending
      '{1,4, 1,3,1, 0, 0,0, 1,0, 0,0, 2,3,0, 8},  // R8 fault to the not-yet-live tail slot
      '{0,0, 1,1,0,15, 0,0, 1,0, 0,0, 3,4,0, 10},
      '{0,0, 0,0,0, 0, 0,0, 1,1,15,0, 3,4,0, 4},
      '{0,0, 0,0,0, 0, 0,0, 1,1,40,0, 2,4,0, 4},
      '{0,0, 1,3,0, 7, 0,0, 1,0, 0,0, 1,4,0, 8},  // R8 slot 3 is pending, not faulted
      '{0,0, 0,0,0, 0, 0,0, 1,1, 7,0, 1,4,0, 4},
      '{0,0, 0,0,0, 0, 0,0, 1,0, 0,0, 0,4,0, 1},  // R1 empty after draining
      '{1,1, 0,0,0, 0, 0,0, 1,0, 0,0, 0,4,0, 3},
      '{1,2, 0,0,0, 0, 0,0, 1,0, 0,0, 1,5,0, 3},
      '{1,3, 0,0,0, 0, 0,0, 1,0, 0,0, 2,0,0, 3},  // R3 tail wrapped to 0
      '{1,4, 0,0,0, 0, 0,0, 1,0, 0,0, 3,1,0, 7},
      '{1,5, 0,0,0, 0, 0,0, 1,0, 0,0, 4,2,0, 7},
      '{1,6, 0,0,0, 0, 0,0, 0,0, 0,0, 5,3,0, 2},  // R2 full at DEPTH-1
      '{0,0, 0,0,0, 0, 0,0, 0,0, 0,0, 5,3,0, 2},  // R2 refused issue left no trace
      '{1,7, 0,0,0, 0, 1,1, 0,0, 0,0, 5,3,1, 6},  // R6 drop one, no wrap
      '{1,7, 0,0,0, 0, 1,5, 0,0, 0,0, 4,2,2, 9},  // R9 flush beats issue; R6 wrap drop 2
      '{0,0, 0,0,0, 0, 0,0, 1,0, 0,0, 2,0,0, 9},  // R9 issue was not taken
      '{0,0, 1,5,0,50, 0,0, 1,0, 0,0, 2,0,0, 10},
      '{0,0, 1,4,1, 0, 0,0, 1,0, 0,0, 2,0,0, 5},
      '{1,1, 0,0,0, 0, 0,0, 0,0, 0,1, 2,0,0, 5},  // R5 faulted head
      '{0,0, 0,0,0, 0, 0,0, 1,0, 0,0, 0,5,0, 5},  // R5 completed younger dropped
      '{1,1, 0,0,0, 0, 0,0, 1,0, 0,0, 0,5,0, 3},
      '{1,2, 0,0,0, 0, 0,0, 1,0, 0,0, 1,0,0, 3},
      '{1,3, 0,0,0, 0, 0,0, 1,0, 0,0, 2,1,0, 3},
      '{1,4, 0,0,0, 0, 0,0, 1,0, 0,0, 3,2,0, 7},
      '{0,0, 0,0,0, 0, 1,0, 0,0, 0,0, 4,3,2, 6},  // R6 branch at slot 0 kept
      '{0,0, 0,0,0, 0, 0,0, 1,0, 0,0, 2,1,0, 7},  // R7 occupancy after flush
      '{0,0, 1,5,0,11, 0,0, 1,0, 0,0, 2,1,0, 10},
      '{0,0, 1,0,0,22, 0,0, 1,1,11,0, 2,1,0, 4},
      '{0,0, 0,0,0, 0, 0,0, 1,1,22,0, 1,1,0, 6},  // R6 kept branch retires
      '{0,0, 0,0,0, 0, 0,0, 1,0, 0,0, 0,1,0, 1}
   };

   task automatic chk(input string what, input int req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      iss_valid = 1'b0; cmp_valid = 1'b0; cmp_fault = 1'b0; br_valid = 1'b0;
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1 reset state
      @(negedge clk); #1;
      chk("reset occupancy", 1, 32'(occupancy), 0);
      chk("reset ret_valid", 1, 32'(ret_valid), 0);
      chk("reset exc_valid", 1, 32'(exc_valid), 0);
      chk("reset iss_slot", 1, 32'(iss_slot), 0);
      @(negedge clk); rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         iss_valid = VEC[k].iv;  iss_dest  = VEC[k].id;
         cmp_valid = VEC[k].cv;  cmp_slot  = VEC[k].cs;
         cmp_fault = VEC[k].cf;  cmp_value = VEC[k].cval;
         br_valid  = VEC[k].bv;  br_slot   = VEC[k].bs;
         #1;
         chk($sformatf("v%0d iss_ready", k), int'(VEC[k].req), 32'(iss_ready), 32'(VEC[k].erdy));
         chk($sformatf("v%0d ret_valid", k), int'(VEC[k].req), 32'(ret_valid), 32'(VEC[k].erv));
         chk($sformatf("v%0d exc_valid", k), int'(VEC[k].req), 32'(exc_valid), 32'(VEC[k].eexc));
         chk($sformatf("v%0d occupancy", k), int'(VEC[k].req), 32'(occupancy), 32'(VEC[k].eocc));
         chk($sformatf("v%0d iss_slot", k), int'(VEC[k].req), 32'(iss_slot), 32'(VEC[k].eslot));
         if (VEC[k].erv)
            chk($sformatf("v%0d ret_value", k), int'(VEC[k].req), 32'(ret_value), 32'(VEC[k].eval));
         if (VEC[k].bv)
            chk($sformatf("v%0d br_drop_cnt", k), int'(VEC[k].req), 32'(br_drop_cnt), 32'(VEC[k].efc));
      end

      // R4 destination travels with the committed entry (state: empty, tail 1)
      @(negedge clk); idle_inputs(); iss_valid = 1'b1; iss_dest = 3'd5; #1;
      chk("issue slot", 3, 32'(iss_slot), 1);
      @(negedge clk); idle_inputs();
      cmp_valid = 1'b1; cmp_slot = 3'd1; cmp_value = 8'h5A; #1;
      chk("pending not retired", 4, 32'(ret_valid), 0);
      @(negedge clk); idle_inputs(); #1;
      chk("ret_valid", 4, 32'(ret_valid), 1);
      chk("ret_dest", 4, 32'(ret_dest), 5);
      chk("ret_value", 4, 32'(ret_value), 32'h5A);

      // R8 out-of-range slot number leaves a pending head pending
      @(negedge clk); idle_inputs(); iss_valid = 1'b1; iss_dest = 3'd2; #1;
      @(negedge clk); idle_inputs();
      cmp_valid = 1'b1; cmp_slot = 3'd7; cmp_fault = 1'b1; #1;
      @(negedge clk); idle_inputs(); #1;
      chk("out-of-range completion", 8, 32'({ret_valid, exc_valid}), 0);
      chk("occupancy kept", 8, 32'(occupancy), 1);

      // R1 reset in mid-run empties the ring
      @(negedge clk); idle_inputs(); rst_n = 1'b0; #1;
      chk("mid reset occupancy", 1, 32'(occupancy), 0);
      chk("mid reset iss_slot", 1, 32'(iss_slot), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule